// File: doc/BRIEF.md
# Data Cache Hit/Miss Test Sequencer

This block runs a self-contained test of a data cache controller from the outside. It walks a generated address sequence twice and issues a write or read for every step on a simple valid/acknowledge request port. Along with every request it publishes the hit or miss outcome the cache should report. When the acknowledge arrives, it compares that outcome with the status taken from a bus monitor. For reads it also checks the returned data.

Addresses are built so that every index and every word offset of the cache is visited. Each tag carries a single odd bit: a lone one in one pass and a lone zero in the other. Consecutive iterations on the same cache line therefore always use different tags, and the second pass always evicts what the first pass left.

The first pass writes a pattern (write miss) and reads it back (read hit). The second pass reads a fresh location (read miss), writes back the value it just got (write hit), and reads it again (read hit). The two reads of the second pass must agree bit for bit. The first wrong status or wrong datum stops the run with an error flag. A clean run ends with a done flag.

Top module: `dct_sequencer`

## Requirements
- R1: Iterations run block index m outer and word index n inner (iteration number k = m*WORDS + n). The request address is BASE plus the concatenation {tag, m, w, zero byte bits}. The word field is w = (m+n) mod WORDS. The tag is one-hot at bit (m+n) mod TAG_W in the marching-one pass and the bitwise inverse of that in the marching-zero pass.
- R2: In pass one each iteration issues two requests to the same address. The first is a write (req_we=1) of PATTERN XOR k with req_exp_hit=0. The second is a read (req_we=0) with req_exp_hit=1.
- R3: If the pass-one read returns data different from the pattern written, err is set.
- R4: Pass two uses the other tag polarity: marching zero when FIRST_MARCH selects marching one first, and marching one otherwise. Each iteration issues three requests to the same address: a read with req_exp_hit=0, a write of the data that read returned with req_exp_hit=1, and a read with req_exp_hit=1.
- R5: If the two pass-two reads of an iteration differ in any bit (nonzero XOR), err is set.
- R6: On any acknowledged request whose mon_hit differs from req_exp_hit, err is set.
- R7: A request holds req_valid high and its address, direction, write data and expected status unchanged until the cycle req_ack is high. The next request appears in the cycle right after that acknowledge.
- R8: A run without mismatch issues exactly 5*BLOCKS*WORDS requests and then raises done.
- R9: err and done are never high together. Each stays high until reset, start is ignored meanwhile, and no further request is issued.
- R10: After reset req_valid, err and done are low, and the block waits for a start pulse before issuing any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| req_valid | output | 1 | Request present |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | TAG_W+log2(BLOCKS)+log2(WORDS)+log2(WORD_BYTES) | Byte address of the request |
| req_wdata | output | DATA_W | Write data |
| req_exp_hit | output | 1 | Expected cache outcome, 1 = hit |
| req_ack | input | 1 | Request accepted; rsp_rdata and mon_hit valid |
| rsp_rdata | input | DATA_W | Read data returned with the acknowledge |
| mon_hit | input | 1 | Hit (1) or miss (0) seen by the bus monitor |
| err | output | 1 | Sticky mismatch flag |
| done | output | 1 | Sticky completion flag |

## Verification
The bench builds the sequencer with 4 blocks of 2 words, 4-byte words, a 4-bit tag, 16-bit data and a base offset that lands in the tag field. With these values a full two-pass run is only 40 requests, so every request can be compared against an independently computed list. A small direct-mapped cache model gives genuine hit and miss answers, which shows that the tag schedule really evicts. Faults are injected at chosen request numbers, so each error path is reached with a known count of requests before the stop.

// File: rtl/dct_pkg.sv
package dct_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_A_WRITE,
      SQ_A_READ,
      SQ_B_READ_X,
      SQ_B_WRITE,
      SQ_B_READ_Y,
      SQ_FAIL,
      SQ_END
   } seq_state_t;

   typedef enum logic {
      MARCH_ONE,
      MARCH_ZERO
   } march_t;

endpackage

// File: rtl/dct_addr_gen.sv
module dct_addr_gen
   import dct_pkg::*;
#(
   parameter int unsigned     BLOCKS      = 512,
   parameter int unsigned     WORDS       = 4,
   parameter int unsigned     WORD_BYTES  = 4,
   parameter int unsigned     TAG_W       = 5,
   parameter longint unsigned BASE        = 0,
   parameter march_t          FIRST_MARCH = MARCH_ONE,
   localparam int unsigned    IDX_W  = $clog2(BLOCKS),
   localparam int unsigned    WRD_W  = $clog2(WORDS),
   localparam int unsigned    BYTE_W = $clog2(WORD_BYTES),
   localparam int unsigned    ADDR_W = TAG_W + IDX_W + WRD_W + BYTE_W,
   localparam int unsigned    ITER_W = IDX_W + WRD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic              pass_two,
   output logic [ADDR_W-1:0] addr,
   output logic [ITER_W-1:0] iter,
   output logic              last
);

   localparam int unsigned POS_W = $clog2(TAG_W);
   localparam int unsigned SUM_W = ((IDX_W > WRD_W) ? IDX_W : WRD_W) + 1;

   logic [IDX_W-1:0] blk_q;
   logic [WRD_W-1:0] wrd_q;
   logic [POS_W-1:0] bpos_q;
   logic [POS_W-1:0] pos_q;
   logic [SUM_W-1:0] diag_sum;
   logic [WRD_W-1:0] word_f;
   logic [TAG_W-1:0] onehot;
   logic [TAG_W-1:0] tag;

   function automatic logic [POS_W-1:0] pos_next(input logic [POS_W-1:0] p);
      return (p == POS_W'(TAG_W - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q  <= '0;
         wrd_q  <= '0;
         bpos_q <= '0;
         pos_q  <= '0;
      end else if (restart) begin
         blk_q  <= '0;
         wrd_q  <= '0;
         bpos_q <= '0;
         pos_q  <= '0;
      end else if (step) begin
         if (wrd_q == WRD_W'(WORDS - 1)) begin
            wrd_q  <= '0;
            blk_q  <= blk_q + 1'b1;
            bpos_q <= pos_next(bpos_q);
            pos_q  <= pos_next(bpos_q);
         end else begin
            wrd_q <= wrd_q + 1'b1;
            pos_q <= pos_next(pos_q);
         end
      end
   end

   assign diag_sum = SUM_W'(blk_q) + SUM_W'(wrd_q);
   assign word_f   = diag_sum[WRD_W-1:0];
   assign onehot   = TAG_W'(1) << pos_q;

   generate
      if (FIRST_MARCH == MARCH_ONE) begin : g_one_first
         assign tag = pass_two ? ~onehot : onehot;
      end else begin : g_zero_first
         assign tag = pass_two ? onehot : ~onehot;
      end
   endgenerate

   assign addr = ADDR_W'(BASE) + {tag, blk_q, word_f, {BYTE_W{1'b0}}};
   assign iter = {blk_q, wrd_q};
   assign last = (blk_q == IDX_W'(BLOCKS - 1)) && (wrd_q == WRD_W'(WORDS - 1));

endmodule

// File: rtl/dct_result_cmp.sv
module dct_result_cmp #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              exp_hit,
   input  logic              hit,
   input  logic              data_chk,
   input  logic [DATA_W-1:0] exp_data,
   input  logic [DATA_W-1:0] rdata,
   output logic              bad
);

   logic [DATA_W-1:0] diff;

   assign diff = exp_data ^ rdata;
   assign bad  = (exp_hit ^ hit) | (data_chk & (|diff));

endmodule

// File: rtl/dct_sequencer.sv
module dct_sequencer
   import dct_pkg::*;
#(
   parameter int unsigned     BLOCKS      = 512,
   parameter int unsigned     WORDS       = 4,
   parameter int unsigned     WORD_BYTES  = 4,
   parameter int unsigned     TAG_W       = 5,
   parameter int unsigned     DATA_W      = 32,
   parameter longint unsigned PATTERN     = 64'hA5A5_5A5A,
   parameter longint unsigned BASE        = 0,
   parameter march_t          FIRST_MARCH = MARCH_ONE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic req_valid,
   output logic req_we,
   output logic [TAG_W+$clog2(BLOCKS)+$clog2(WORDS)+$clog2(WORD_BYTES)-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   output logic req_exp_hit,
   input  logic req_ack,
   input  logic [DATA_W-1:0] rsp_rdata,
   input  logic mon_hit,
   output logic err,
   output logic done
);

   localparam int unsigned IDX_W  = $clog2(BLOCKS);
   localparam int unsigned WRD_W  = $clog2(WORDS);
   localparam int unsigned BYTE_W = $clog2(WORD_BYTES);
   localparam int unsigned ADDR_W = TAG_W + IDX_W + WRD_W + BYTE_W;
   localparam int unsigned ITER_W = IDX_W + WRD_W;
   localparam logic [DATA_W-1:0] PAT_C = DATA_W'(PATTERN);

   initial begin
      assert (BLOCKS >= 2 && (1 << IDX_W) == BLOCKS)
         else $error("BLOCKS must be a power of two, at least 2");
      assert (WORDS >= 2 && (1 << WRD_W) == WORDS)
         else $error("WORDS must be a power of two, at least 2");
      assert (WORD_BYTES >= 2 && (1 << BYTE_W) == WORD_BYTES)
         else $error("WORD_BYTES must be a power of two, at least 2");
      assert (TAG_W >= 3 && WORDS <= TAG_W)
         else $error("TAG_W must be at least 3 and not below WORDS");
      assert (DATA_W >= 1 && DATA_W <= 64)
         else $error("DATA_W out of range");
   end

   seq_state_t        state_q, state_d;
   logic [DATA_W-1:0] rx_q;
   logic [ITER_W-1:0] iter;
   logic              last;
   logic              pass_two;
   logic              restart;
   logic              step;
   logic              ack_fire;
   logic              bad;
   logic              data_chk;
   logic [DATA_W-1:0] pattern;
   logic [DATA_W-1:0] exp_data;

   assign pass_two = (state_q == SQ_B_READ_X) || (state_q == SQ_B_WRITE) ||
                     (state_q == SQ_B_READ_Y);
   assign req_valid = (state_q == SQ_A_WRITE) || (state_q == SQ_A_READ) || pass_two;
   assign req_we    = (state_q == SQ_A_WRITE) || (state_q == SQ_B_WRITE);
   assign req_exp_hit = (state_q == SQ_A_READ) || (state_q == SQ_B_WRITE) ||
                        (state_q == SQ_B_READ_Y);
   assign ack_fire  = req_valid && req_ack;
   assign pattern   = PAT_C ^ DATA_W'(iter);
   assign req_wdata = (state_q == SQ_B_WRITE) ? rx_q : pattern;
   assign data_chk  = (state_q == SQ_A_READ) || (state_q == SQ_B_READ_Y);
   assign exp_data  = (state_q == SQ_A_READ) ? pattern : rx_q;
   assign err  = (state_q == SQ_FAIL);
   assign done = (state_q == SQ_END);

   dct_addr_gen #(
      .BLOCKS     (BLOCKS),
      .WORDS      (WORDS),
      .WORD_BYTES (WORD_BYTES),
      .TAG_W      (TAG_W),
      .BASE       (BASE),
      .FIRST_MARCH(FIRST_MARCH)
   ) u_addr_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (step),
      .pass_two(pass_two),
      .addr    (req_addr),
      .iter    (iter),
      .last    (last)
   );

   dct_result_cmp #(
      .DATA_W(DATA_W)
   ) u_cmp (
      .exp_hit (req_exp_hit),
      .hit     (mon_hit),
      .data_chk(data_chk),
      .exp_data(exp_data),
      .rdata   (rsp_rdata),
      .bad     (bad)
   );

   always_comb begin
      state_d = state_q;
      restart = 1'b0;
      step    = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (start) begin
               state_d = SQ_A_WRITE;
               restart = 1'b1;
            end
         end
         SQ_A_WRITE: begin
            if (ack_fire) state_d = bad ? SQ_FAIL : SQ_A_READ;
         end
         SQ_A_READ: begin
            if (ack_fire) begin
               if (bad) begin
                  state_d = SQ_FAIL;
               end else if (last) begin
                  state_d = SQ_B_READ_X;
                  restart = 1'b1;
               end else begin
                  state_d = SQ_A_WRITE;
                  step    = 1'b1;
               end
            end
         end
         SQ_B_READ_X: begin
            if (ack_fire) state_d = bad ? SQ_FAIL : SQ_B_WRITE;
         end
         SQ_B_WRITE: begin
            if (ack_fire) state_d = bad ? SQ_FAIL : SQ_B_READ_Y;
         end
         SQ_B_READ_Y: begin
            if (ack_fire) begin
               if (bad) begin
                  state_d = SQ_FAIL;
               end else if (last) begin
                  state_d = SQ_END;
               end else begin
                  state_d = SQ_B_READ_X;
                  step    = 1'b1;
               end
            end
         end
         SQ_FAIL: state_d = SQ_FAIL;
         SQ_END:  state_d = SQ_END;
         default: state_d = SQ_FAIL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         rx_q    <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_B_READ_X && ack_fire) rx_q <= rsp_rdata;
      end
   end

endmodule

// File: rtl/dct_sequencer_sva.sv
module dct_sequencer_sva #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_we,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              req_exp_hit,
   input logic              req_ack,
   input logic              mon_hit,
   input logic              err,
   input logic              done
);

   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_we) &&
                                $stable(req_wdata) && $stable(req_exp_hit));

   a_r6_status_mismatch_fails: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack && (req_exp_hit != mon_hit) |=> err);

   a_r2_readback_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack && req_we && !req_exp_hit && !mon_hit |=>
         req_valid && !req_we && req_exp_hit && $stable(req_addr));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   a_r9_quiet_when_finished: assert property (@(posedge clk) disable iff (!rst_n)
      (err || done) |-> !req_valid);

   a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && done));

endmodule

bind dct_sequencer dct_sequencer_sva #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_we     (req_we),
   .req_addr   (req_addr),
   .req_wdata  (req_wdata),
   .req_exp_hit(req_exp_hit),
   .req_ack    (req_ack),
   .mon_hit    (mon_hit),
   .err        (err),
   .done       (done)
);

// File: tb/test_dct_sequencer.sv
`timescale 1ns/1ps
module test_dct_sequencer;

   localparam int BLK  = 4;
   localparam int WRD  = 2;
   localparam int WB   = 4;
   localparam int TW   = 4;
   localparam int DW   = 16;
   localparam int AW   = 9;
   localparam int PAT  = 'hC3A5;
   localparam int BASE = 'h040;
   localparam int ITN  = BLK * WRD;
   localparam int NREQ = 5 * ITN;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          req_valid;
   logic          req_we;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          req_exp_hit;
   logic          req_ack = 1'b0;
   logic [DW-1:0] rsp_rdata = '0;
   logic          mon_hit = 1'b0;
   logic          err;
   logic          done;

   int n_chk  = 0;
   int n_fail = 0;

   int e_addr [NREQ];
   int e_we   [NREQ];
   int e_wd   [NREQ];
   int e_eh   [NREQ];

   logic [DW-1:0] mem [int];
   logic          c_vld [BLK];
   int            c_tag [BLK];

   always #4 clk = ~clk;

   dct_sequencer #(
      .BLOCKS    (BLK),
      .WORDS     (WRD),
      .WORD_BYTES(WB),
      .TAG_W     (TW),
      .DATA_W    (DW),
      .PATTERN   (PAT),
      .BASE      (BASE)
   ) i_dct_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .req_valid  (req_valid),
      .req_we     (req_we),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_exp_hit(req_exp_hit),
      .req_ack    (req_ack),
      .rsp_rdata  (rsp_rdata),
      .mon_hit    (mon_hit),
      .err        (err),
      .done       (done)
   );

   task automatic chk(input string rq, input longint act, input longint exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int calc_addr(input int pass, input int m, input int n);
      int s = m + n;
      int tag = 1 << (s % TW);
      if (pass != 0) tag = (~tag) & ((1 << TW) - 1);
      return (BASE + ((tag << 5) | (m << 3) | ((s % WRD) << 2))) & ((1 << AW) - 1);
   endfunction

   function automatic int init_val(input int a);
      return (a ^ 'h5A3C) & 'hFFFF;
   endfunction

   task automatic build_expect();
      for (int k = 0; k < ITN; k++) begin
         int a1 = calc_addr(0, k / WRD, k % WRD);
         int a2 = calc_addr(1, k / WRD, k % WRD);
         e_addr[2*k] = a1;   e_we[2*k] = 1;   e_wd[2*k] = (PAT ^ k) & 'hFFFF; e_eh[2*k] = 0;
         e_addr[2*k+1] = a1; e_we[2*k+1] = 0; e_wd[2*k+1] = 0;                e_eh[2*k+1] = 1;
         e_addr[2*ITN+3*k]   = a2; e_we[2*ITN+3*k]   = 0; e_wd[2*ITN+3*k]   = 0;
         e_eh[2*ITN+3*k]     = 0;
         e_addr[2*ITN+3*k+1] = a2; e_we[2*ITN+3*k+1] = 1; e_wd[2*ITN+3*k+1] = init_val(a2);
         e_eh[2*ITN+3*k+1]   = 1;
         e_addr[2*ITN+3*k+2] = a2; e_we[2*ITN+3*k+2] = 0; e_wd[2*ITN+3*k+2] = 0;
         e_eh[2*ITN+3*k+2]   = 1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start = 1'b0; req_ack = 1'b0; mon_hit = 1'b0; rsp_rdata = '0;
      mem.delete();
      for (int i = 0; i < BLK; i++) begin c_vld[i] = 1'b0; c_tag[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic check_fields(input int r);
      string t = (r >= 2 * ITN) ? "R4" : "R2";
      if (r >= NREQ) begin
         chk("R8", r, NREQ - 1, "request beyond expected count");
         return;
      end
      chk("R1", int'(req_addr), e_addr[r], $sformatf("address of request %0d", r));
      chk(t, int'(req_we), e_we[r], $sformatf("direction of request %0d", r));
      chk(t, int'(req_exp_hit), e_eh[r], $sformatf("expected status of request %0d", r));
      if (e_we[r] != 0)
         chk(t, int'(req_wdata), e_wd[r], $sformatf("write data of request %0d", r));
   endtask

   task automatic respond(input int r, input int f_idx, input int f_kind);
      int a   = int'(req_addr);
      int idx = (a >> 3) % BLK;
      int tg  = a >> 5;
      logic h = c_vld[idx] && (c_tag[idx] == tg);
      logic [DW-1:0] d = '0;
      c_vld[idx] = 1'b1;
      c_tag[idx] = tg;
      if (req_we) mem[a] = req_wdata;
      else d = mem.exists(a) ? mem[a] : DW'(init_val(a));
      if (r == f_idx && f_kind == 1) h = ~h;
      if (r == f_idx && f_kind == 2) d = d ^ 16'h0001;
      mon_hit   = h;
      rsp_rdata = d;
   endtask

   task automatic run_seq(input int slow, input int f_idx, input int f_kind, output int nreq);
      int w = 0;
      int lat;
      int quiet_viol = 0;
      logic acked = 1'b0;
      logic [AW-1:0] h_addr = '0;
      logic [DW-1:0] h_wd = '0;
      logic h_we = 1'b0;
      logic h_eh = 1'b0;
      do_reset();
      pulse_start();
      nreq = 0;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         req_ack = 1'b0;
         if (err || done) break;
         if (acked && nreq < NREQ)
            chk("R7", int'(req_valid), 1, "request right after acknowledge");
         acked = 1'b0;
         if (req_valid) begin
            if (w == 0) begin
               h_addr = req_addr; h_we = req_we; h_wd = req_wdata; h_eh = req_exp_hit;
               check_fields(nreq);
            end else begin
               chk("R7", int'(req_addr), int'(h_addr), "address held while waiting");
               chk("R7", int'(req_we), int'(h_we), "direction held while waiting");
               chk("R7", int'(req_wdata), int'(h_wd), "write data held while waiting");
               chk("R7", int'(req_exp_hit), int'(h_eh), "status held while waiting");
            end
            lat = (slow != 0) ? (nreq % 4) : 0;
            if (w >= lat) begin
               respond(nreq, f_idx, f_kind);
               req_ack = 1'b1;
               nreq++;
               w = 0;
               acked = 1'b1;
            end else begin
               w++;
            end
         end
      end
      req_ack = 1'b0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (req_valid) quiet_viol++;
      end
      chk("R9", quiet_viol, 0, "requests after run ended");
   endtask

   task automatic t_reset();
      do_reset();
      chk("R10", int'(req_valid), 0, "req_valid after reset");
      chk("R10", int'(err), 0, "err after reset");
      chk("R10", int'(done), 0, "done after reset");
      repeat (6) @(negedge clk);
      chk("R10", int'(req_valid), 0, "no request without start");
   endtask

   task automatic t_clean(input int slow);
      int n;
      run_seq(slow, -1, 0, n);
      chk("R8", int'(done), 1, "done after clean run");
      chk("R8", int'(err), 0, "err after clean run");
      chk("R8", n, NREQ, "request count of clean run");
   endtask

   task automatic t_fault(input int f_idx, input int f_kind, input string rq);
      int n;
      run_seq(0, f_idx, f_kind, n);
      chk(rq, int'(err), 1, $sformatf("err after fault at request %0d", f_idx));
      chk(rq, int'(done), 0, $sformatf("done after fault at request %0d", f_idx));
      chk(rq, n, f_idx + 1, "requests issued before stop");
   endtask

   task automatic t_sticky();
      int n;
      int seen = 0;
      run_seq(0, 3, 1, n);
      pulse_start();
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (req_valid) seen++;
      end
      chk("R9", int'(err), 1, "err held after restart attempt");
      chk("R9", int'(done), 0, "done stays low with err");
      chk("R9", seen, 0, "start ignored after err");
      run_seq(1, -1, 0, n);
      pulse_start();
      seen = 0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (req_valid) seen++;
      end
      chk("R9", int'(done), 1, "done held after restart attempt");
      chk("R9", int'(err), 0, "err stays low with done");
      chk("R9", seen, 0, "start ignored after done");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      build_expect();
      t_reset();
      t_clean(0);
      t_clean(1);
      t_fault(0, 1, "R6");
      t_fault(2 * ITN + 3 * 1 + 1, 1, "R6");
      t_fault(5, 2, "R3");
      t_fault(2 * ITN + 3 * 2 + 2, 2, "R5");
      t_sticky();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule